// File: doc/BRIEF.md
# Descriptor-Driven NAND Data Mover

This engine moves the data phase of a NAND transfer between system memory and the byte-wide FIFOs of a NAND data path. Software prepares a descriptor in memory and writes its address into the engine's base register. A data command then supplies a direction and a byte count. The engine fetches the descriptor over a 64-bit memory request/acknowledge port and checks the ownership bit. It streams the buffer one byte per cycle, to the transmit FIFO when writing to flash or from the receive FIFO when reading from flash. At the end it returns the descriptor to software and pulses a completion event.

A descriptor is four 32-bit words, stored little-endian in two 8-byte beats. The first beat holds the status word (low half) and the sizes word (high half). The second beat holds buffer pointer 0 (low half) and buffer pointer 1 (high half, unused). In the status word, bit 31 is the hardware-ownership flag, bit 3 marks a first descriptor and bit 2 marks a last one. Sizes bits 11:0 hold a buffer length that software rounds up to a multiple of 8. The engine does not use that length: the command count decides how many bytes move. A descriptor still owned by software produces a "no descriptor" event, and no data moves.

The state machine has ten states. IDLE waits for a command. DESC_LO fetches the status/sizes beat, and DESC_HI fetches the pointer beat. NODESC reports a software-owned descriptor. BEAT_RD reads one 8-byte buffer beat, and TX_PUSH hands its bytes to the transmit FIFO. RX_PULL gathers receive bytes into a beat, and BEAT_WR stores that beat. WBACK writes the status beat back, and DONE pulses completion. The transitions are:
- IDLE to DESC_LO on a command.
- DESC_LO to DESC_HI (owned) or to NODESC (not owned), on acknowledge.
- DESC_HI to BEAT_RD (outbound) or to RX_PULL (inbound).
- BEAT_RD to TX_PUSH.
- TX_PUSH back to BEAT_RD after lane 7, or to WBACK after the final byte.
- RX_PULL to BEAT_WR after lane 7 or after the final byte.
- BEAT_WR back to RX_PULL, or to WBACK when no bytes remain.
- WBACK to DONE, then DONE to IDLE.
- NODESC to IDLE.

Top module: `nand_desc_dma`

## Requirements
- R1: After reset the engine is idle. busy, mem_req, tx_valid, rx_pop and all three event outputs are low.
- R2: A register write with reg_addr equal to 0x18 loads the descriptor base, and writes to any other offset leave it unchanged. The base is captured when a command is accepted. The first memory request of a transfer reads the beat at that base, and the second reads base+8.
- R3: If status bit 31 of the fetched descriptor is 0, ev_no_desc pulses for one cycle. The engine then returns to idle with no FIFO traffic and no memory write.
- R4: For cmd_dir=0 (outbound), the engine reads 8-byte beats at pointer 0, pointer 0 + 8, and so on. It presents exactly cmd_len_m1+1 bytes on tx_data, lane 0 (bits 7:0) first. tx_valid and tx_data hold until tx_ready.
- R5: For cmd_dir=1 (inbound), the engine pops exactly cmd_len_m1+1 bytes, filling lanes in ascending order. It writes each beat in ascending address order, with unused lanes of the final beat set to zero.
- R6: After the data phase, the engine writes the first descriptor beat back to the base with bit 31 of status cleared. All other status bits and the sizes word are kept. The write completes before a single-cycle ev_tx_done (outbound) or ev_rx_done (inbound).
- R7: cmd_valid is ignored while busy is high. The running transfer continues unchanged.
- R8: While mem_req is high without mem_ack, mem_req, mem_addr, mem_we and mem_wdata stay stable on the next cycle.
- R9: A command moves cmd_len_m1+1 bytes, from 1 to 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset; 0x18 selects the descriptor base |
| reg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | Data command strobe |
| cmd_dir | input | 1 | 0 = memory to transmit FIFO, 1 = receive FIFO to memory |
| cmd_len_m1 | input | 12 | Byte count minus one |
| busy | output | 1 | High whenever the engine is not idle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write beat |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 64 | Read beat |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit FIFO accepts the byte |
| rx_valid | input | 1 | Receive FIFO holds a byte |
| rx_data | input | 8 | Receive byte |
| rx_pop | output | 1 | Receive byte taken this cycle |
| ev_tx_done | output | 1 | Outbound transfer finished (one cycle) |
| ev_rx_done | output | 1 | Inbound transfer finished (one cycle) |
| ev_no_desc | output | 1 | Descriptor not owned by hardware (one cycle) |

## Verification
A wrong lane counter or remaining-byte count shows up as a missing, extra or misplaced byte. It appears on tx_data or in the next memory beat write, within the beat where it occurs. A wrong ownership decision is seen within a few cycles of the first acknowledge: either a spurious ev_no_desc or FIFO traffic that should not exist. A wrong write-back shows in the descriptor beat in memory at the moment the completion event fires.

// File: rtl/nddma_pkg.sv
package nddma_pkg;
    localparam int OWN_BIT = 31;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DESC_LO,
        S_DESC_HI,
        S_NODESC,
        S_BEAT_RD,
        S_TX_PUSH,
        S_RX_PULL,
        S_BEAT_WR,
        S_WBACK,
        S_DONE
    } nddma_state_e;
endpackage

// File: rtl/nddma_cnt.sv
module nddma_cnt #(
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int LW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  len,
    input  logic              step,
    input  logic              beat_adv,
    output logic [CNT_W-1:0]  rem,
    output logic [LW-1:0]     lane,
    output logic [ADDR_W-1:0] off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            lane <= '0;
            off  <= '0;
        end else if (load) begin
            rem  <= len;
            lane <= '0;
            off  <= '0;
        end else begin
            if (step) begin
                rem  <= rem - 1'b1;
                lane <= lane + 1'b1;
            end
            if (beat_adv) begin
                off  <= off + ADDR_W'(LANES);
                lane <= '0;
            end
        end
    end

    // R9
    rem_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> rem != '0);
endmodule

// File: rtl/nddma_lane.sv
module nddma_lane #(
    parameter int LANES = 8,
    localparam int LW   = $clog2(LANES),
    localparam int BW   = 8 * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] beat_in,
    input  logic          clr,
    input  logic          put,
    input  logic [LW-1:0] lane,
    input  logic [7:0]    byte_in,
    output logic [BW-1:0] beat,
    output logic [7:0]    byte_out
);
    logic [7:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (load)
                lane_q[g] <= beat_in[g*8 +: 8];
            else if (clr)
                lane_q[g] <= '0;
            else if (put && lane == LW'(g))
                lane_q[g] <= byte_in;
        end
        assign beat[g*8 +: 8] = lane_q[g];
    end

    assign byte_out = lane_q[lane];
endmodule

// File: rtl/nand_desc_dma.sv
module nand_desc_dma
    import nddma_pkg::*;
#(
    parameter int LEN_W    = 12,
    parameter int ADDR_W   = 32,
    parameter int RA_W     = 12,
    parameter int BASE_OFS = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              cmd_valid,
    input  logic              cmd_dir,
    input  logic [LEN_W-1:0]  cmd_len_m1,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    output logic              ev_tx_done,
    output logic              ev_rx_done,
    output logic              ev_no_desc
);
    localparam int LANES = 8;
    localparam int LW    = $clog2(LANES);
    localparam int CNT_W = LEN_W + 1;

    nddma_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_reg, base_q, ptr_q;
    logic [31:0]       status_q, sizes_q;
    logic              dir_q;
    logic [CNT_W-1:0]  rem;
    logic [LW-1:0]     lane;
    logic [ADDR_W-1:0] off;
    logic [63:0]       beat;
    logic [7:0]        lane_byte;

    wire accept    = (state_q == S_IDLE) && cmd_valid;
    wire step      = (tx_valid && tx_ready) || rx_pop;
    wire beat_adv  = ((state_q == S_BEAT_RD) || (state_q == S_BEAT_WR)) && mem_ack;
    wire beat_load = (state_q == S_BEAT_RD) && mem_ack;
    wire beat_clr  = ((state_q == S_DESC_HI) || (state_q == S_BEAT_WR)) && mem_ack;
    wire lane_last = (lane == LW'(LANES - 1));
    wire rem_last  = (rem == CNT_W'(1));

    nddma_cnt #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .len(CNT_W'(cmd_len_m1) + CNT_W'(1)),
        .step(step), .beat_adv(beat_adv),
        .rem(rem), .lane(lane), .off(off)
    );

    nddma_lane #(.LANES(LANES)) u_lane (
        .clk(clk), .rst_n(rst_n), .load(beat_load), .beat_in(mem_rdata),
        .clr(beat_clr), .put(rx_pop), .lane(lane), .byte_in(rx_data),
        .beat(beat), .byte_out(lane_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_reg <= '0;
            base_q   <= '0;
            ptr_q    <= '0;
            status_q <= '0;
            sizes_q  <= '0;
            dir_q    <= 1'b0;
        end else begin
            if (reg_we && reg_addr == RA_W'(BASE_OFS))
                base_reg <= ADDR_W'(reg_wdata);
            if (accept) begin
                base_q <= base_reg;
                dir_q  <= cmd_dir;
            end
            if (state_q == S_DESC_LO && mem_ack) begin
                status_q <= mem_rdata[31:0];
                sizes_q  <= mem_rdata[63:32];
            end
            if (state_q == S_DESC_HI && mem_ack)
                ptr_q <= ADDR_W'(mem_rdata[31:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (cmd_valid) state_d = S_DESC_LO;
            S_DESC_LO: if (mem_ack) state_d = mem_rdata[OWN_BIT] ? S_DESC_HI : S_NODESC;
            S_DESC_HI: if (mem_ack) state_d = dir_q ? S_RX_PULL : S_BEAT_RD;
            S_NODESC:  state_d = S_IDLE;
            S_BEAT_RD: if (mem_ack) state_d = S_TX_PUSH;
            S_TX_PUSH: if (tx_ready) state_d = rem_last ? S_WBACK :
                                               (lane_last ? S_BEAT_RD : S_TX_PUSH);
            S_RX_PULL: if (rx_valid && (rem_last || lane_last)) state_d = S_BEAT_WR;
            S_BEAT_WR: if (mem_ack) state_d = (rem == '0) ? S_WBACK : S_RX_PULL;
            S_WBACK:   if (mem_ack) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tx_valid   = 1'b0;
        tx_data    = '0;
        rx_pop     = 1'b0;
        ev_tx_done = 1'b0;
        ev_rx_done = 1'b0;
        ev_no_desc = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_DESC_LO: begin
                mem_req  = 1'b1;
                mem_addr = base_q;
            end
            S_DESC_HI: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(LANES);
            end
            S_NODESC: ev_no_desc = 1'b1;
            S_BEAT_RD: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + off;
            end
            S_TX_PUSH: begin
                tx_valid = 1'b1;
                tx_data  = lane_byte;
            end
            S_RX_PULL: rx_pop = rx_valid;
            S_BEAT_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q + off;
                mem_wdata = beat;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = {sizes_q, 1'b0, status_q[30:0]};
            end
            S_DONE: begin
                ev_tx_done = !dir_q;
                ev_rx_done = dir_q;
            end
            default: ;
        endcase
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
    // R6
    event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_tx_done, ev_rx_done, ev_no_desc}));
    // R3
    nodesc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_no_desc |=> !busy);
    // R7
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_valid |=> busy);
    // R3
    nodesc_no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_no_desc |-> !tx_valid && !rx_pop && !mem_req);
endmodule

// File: tb/nand_desc_dma_tb.sv
`timescale 1ns/1ps
module nand_desc_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        cmd_valid = 1'b0, cmd_dir = 1'b0;
    logic [11:0] cmd_len_m1 = '0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_pop, ev_tx_done, ev_rx_done, ev_no_desc;

    always #4 clk = ~clk;

    nand_desc_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
        .cmd_len_m1(cmd_len_m1), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_pop(rx_pop), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .ev_no_desc(ev_no_desc)
    );

    int checks = 0, fails = 0;
    logic [63:0] mem [0:255];
    logic [7:0]  exp_b [0:4095];
    logic [7:0]  got   [0:4095];
    logic [7:0]  in_b  [0:4095];
    int tx_cnt = 0, rx_idx = 0, rx_len = 0, wr_cnt = 0, lat = 0;
    int n_txd = 0, n_rxd = 0, n_nod = 0, hold_viol = 0, cycles = 0;
    bit rx_take = 0, first_pend = 0, p_wait = 0, finished = 0;
    logic [31:0] first_addr = '0, p_addr = '0, cur_base = '0;
    logic [63:0] wb_at_done = '0;

    function automatic logic [7:0] byte_at(logic [31:0] a);
        return mem[a[10:3]][a[2:0]*8 +: 8];
    endfunction

    function automatic logic [63:0] exp_wb(logic [31:0] st, logic [31:0] sz);
        return {sz, 1'b0, st[30:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // memory model with random latency and R8 hold monitor
    initial forever begin
        @(negedge clk);
        if (p_wait && (!mem_req || mem_addr != p_addr)) hold_viol++;
        if (first_pend && mem_req) begin first_addr = mem_addr; first_pend = 0; end
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (lat == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[10:3]];
                if (mem_we) begin mem[mem_addr[10:3]] = mem_wdata; wr_cnt++; end
                lat = $urandom % 3;
            end else lat--;
        end
        p_wait = mem_req && !mem_ack;
        p_addr = mem_addr;
    end

    // transmit sink
    initial forever begin
        @(negedge clk);
        tx_ready = ($urandom % 4) != 0;
        if (tx_valid && tx_ready) begin
            if (tx_cnt < 4096) got[tx_cnt] = tx_data;
            tx_cnt++;
        end
    end

    // receive source
    initial forever begin
        @(negedge clk);
        if (rx_take) rx_idx++;
        rx_valid = (rx_idx < rx_len) && (($urandom % 4) != 0);
        rx_data  = rx_valid ? in_b[rx_idx] : 8'h00;
        #1;
        rx_take = rx_valid && rx_pop;
    end

    // event monitor
    initial forever begin
        @(negedge clk);
        if (ev_tx_done) n_txd++;
        if (ev_rx_done) n_rxd++;
        if (ev_no_desc) n_nod++;
        if (ev_tx_done || ev_rx_done) wb_at_done = mem[cur_base[10:3]];
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic reg_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_cmd(bit dir, int len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dir = dir; cmd_len_m1 = 12'(len - 1);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_xfer(bit dir, int len, logic [31:0] base, logic [31:0] ptr,
                            logic [31:0] st, logic [31:0] sz, bit ignore_test);
        int beats = (len + 7) / 8;
        mem[base[10:3]]     = {sz, st};
        mem[base[10:3] + 1] = {32'h0, ptr};
        for (int i = 0; i < len; i++) exp_b[i] = byte_at(ptr + 32'(i));
        if (dir) begin
            for (int i = 0; i < beats; i++) mem[ptr[10:3] + 8'(i)] = {8{8'hAA}};
            for (int i = 0; i < len; i++) in_b[i] = 8'($urandom);
        end
        tx_cnt = 0; wr_cnt = 0; n_txd = 0; n_rxd = 0; n_nod = 0; hold_viol = 0;
        rx_idx = 0; rx_len = dir ? len : 0; cur_base = base; first_pend = 1;
        pulse_cmd(dir, len);
        if (ignore_test) begin
            repeat (5) @(negedge clk);
            pulse_cmd(!dir, 3);
        end
        wait_idle();
        // R2: descriptor fetched from base
        chk(first_addr == base, "R2", "first fetch addr", first_addr, base);
        // R8: request held until acknowledge
        chk(hold_viol == 0, "R8", "hold violations", hold_viol, 0);
        if (st[31] == 1'b0) begin
            // R3
            chk(n_nod == 1, "R3", "no-desc events", n_nod, 1);
            chk(tx_cnt == 0 && rx_idx == 0 && wr_cnt == 0, "R3", "traffic",
                tx_cnt + rx_idx + wr_cnt, 0);
            chk(n_txd + n_rxd == 0, "R3", "done events", n_txd + n_rxd, 0);
            return;
        end
        if (!dir) begin
            bit ok = 1;
            // R4, R9
            chk(tx_cnt == len, "R4", "tx byte count (R9 length)", tx_cnt, len);
            for (int i = 0; i < len && i < tx_cnt; i++) if (got[i] !== exp_b[i]) ok = 0;
            chk(ok, "R4", "tx byte content", ok, 1);
            chk(n_txd == 1 && n_rxd == 0, "R6", "tx done events", n_txd * 16 + n_rxd, 16);
        end else begin
            bit ok = 1;
            // R5, R9
            chk(rx_idx == len, "R5", "rx pop count (R9 length)", rx_idx, len);
            for (int i = 0; i < beats * 8; i++) begin
                logic [7:0] e = (i < len) ? in_b[i] : 8'h00;
                if (byte_at(ptr + 32'(i)) !== e) ok = 0;
            end
            chk(ok, "R5", "stored beats incl zero pad", ok, 1);
            chk(n_rxd == 1 && n_txd == 0, "R6", "rx done events", n_rxd * 16 + n_txd, 16);
        end
        // R6: write-back visible at the completion event
        chk(wb_at_done == exp_wb(st, sz), "R6", "write-back beat", wb_at_done, exp_wb(st, sz));
        if (ignore_test)
            // R7: second command had no effect
            chk(n_nod + (dir ? n_txd : n_rxd) == 0 && (dir ? tx_cnt : rx_idx) == 0,
                "R7", "ignored command effect", n_nod + tx_cnt, 0);
    endtask

    initial begin
        void'($urandom(20240611));
        for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !mem_req && !tx_valid && !rx_pop, "R1", "idle outputs",
            {busy, mem_req, tx_valid, rx_pop}, 0);
        chk(!ev_tx_done && !ev_rx_done && !ev_no_desc, "R1", "events at reset",
            {ev_tx_done, ev_rx_done, ev_no_desc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after reset release", {busy, mem_req}, 0);

        reg_write(12'h018, 32'h100);
        reg_write(12'h01C, 32'h300);   // R2: wrong offset, must not move the base
        run_xfer(0, 1,  32'h100, 32'h400, 32'h8000_000C, 32'h8, 0);
        run_xfer(0, 8,  32'h100, 32'h408, 32'h8000_000C, 32'h8, 0);
        run_xfer(0, 9,  32'h100, 32'h410, 32'h8000_0004, 32'h10, 0);
        run_xfer(1, 1,  32'h100, 32'h440, 32'h8000_000C, 32'h8, 0);
        run_xfer(1, 8,  32'h100, 32'h448, 32'h8000_000C, 32'h8, 0);
        run_xfer(1, 13, 32'h100, 32'h450, 32'h8000_0008, 32'h10, 0);
        run_xfer(0, 5,  32'h100, 32'h480, 32'h0000_000C, 32'h8, 0);   // R3
        run_xfer(1, 5,  32'h100, 32'h480, 32'h7FFF_FFFF, 32'h8, 0);   // R3
        run_xfer(0, 20, 32'h100, 32'h4C0, 32'h8000_000C, 32'h18, 1);  // R7
        run_xfer(1, 20, 32'h100, 32'h4C0, 32'h8000_000C, 32'h18, 1);  // R7
        reg_write(12'h018, 32'h180);   // R2: new base
        run_xfer(1, 30, 32'h180, 32'h500, 32'h8000_0000, 32'h20, 0);
        run_xfer(0, 4096, 32'h180, 32'h400, 32'hC000_000C, 32'h0, 0);   // R9 maximum
        for (int k = 0; k < 12; k++) begin
            bit d = $urandom % 2;
            int l = 1 + ($urandom % 100);
            logic [31:0] p = 32'h400 + 32'(($urandom % 64) * 8);
            logic [31:0] s = {1'b1, 31'($urandom)};
            run_xfer(d, l, 32'h180, p, s, 32'($urandom), 0);
        end
        finished = 1;
        finish_run();
    end
endmodule